// File: doc/BRIEF.md
# Slow-Tick Register Write Synchronizer

This block sits between a fast bus clock and a set of timekeeping registers that may only change on a slow tick. A bus write to one of the synchronized targets is captured in one holding register and a pending flag rises. The value lands in its target on the next slow commit tick. At that commit the pending flag clears and a sticky completion flag is set. Software polls or waits on these flags before it issues the next write. The bus is never stalled. A write that arrives while another is still waiting is thrown away.

The slow tick arrives as a raw, asynchronous slow-clock level. It passes through a synchronizer chain and becomes a single-cycle rising-edge pulse. It is then optionally divided down by a prescaler, nominally from 32.768 kHz to one pulse per second. The prescaler enable is itself one of the synchronized registers. With it cleared, every raw rising edge is a commit opportunity.

Top module: `tick_write_sync`

## Requirements
- R1: After reset, pendFlag and doneFlag are 0, timeVal, alarmVal, intCtl and swVal are 0, and prenVal is 1.
- R2: A bus write (busWr high for one cycle) to a mapped address while nothing is pending makes pendFlag read 1 from the next cycle on. The target output keeps its old value until a commit.
- R3: On a commit tick with a write pending, the captured data is copied into the target register and pendFlag returns to 0. Outside commits, no target output changes.
- R4: doneFlag becomes 1 on every commit and stays 1 until a cycle with doneClr high and no commit. A commit in the same cycle as doneClr leaves doneFlag at 1.
- R5: A write that arrives while a write is pending and no commit occurs in that cycle is discarded. It never reaches any target.
- R6: A write that arrives in the same cycle as a commit is accepted as the next pending write, and pendFlag stays 1.
- R7: With prenVal at 1, commit ticks occur once every PRESCALE_DIV rising edges of rawTick. With prenVal at 0, a commit tick occurs on every rising edge.
- R8: rawTick goes through a two-stage synchronizer. When prenVal is 0, a pending write reaches its target on the third bus clock edge after rawTick rises.
- R9: Address map: 0 time (full width), 1 alarm (full width), 2 interrupt control (low ICTL_W bits of the data), 3 stopwatch (full width), 4 prescaler enable (data bit 0). Writes to addresses 5 to 7 are ignored and do not raise pendFlag.
- R10: A write to the prescaler enable changes prenVal only at a commit, like any other target.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Single-cycle write strobe |
| busAddr | input | 3 | Target select for the write |
| busData | input | DATA_W | Write data |
| rawTick | input | 1 | Raw slow clock level, asynchronous to clk |
| doneClr | input | 1 | Clears the completion flag |
| timeVal | output | DATA_W | Committed time register |
| alarmVal | output | DATA_W | Committed alarm register |
| intCtl | output | ICTL_W | Committed interrupt control register |
| swVal | output | DATA_W | Committed stopwatch register |
| prenVal | output | 1 | Committed prescaler enable |
| pendFlag | output | 1 | A write is waiting for its commit tick |
| doneFlag | output | 1 | Sticky: a write has committed |

## Verification
The hardest situation to reach is a bus write that lands in exactly the cycle a commit happens, because the commit instant is set by an asynchronous slow clock seen through a synchronizer and a prescaler. The stimulus keeps the write strobe asserted every cycle with changing data across a pending window. Some cycle is then bound to coincide with the commit, and the accepted hand-over shows as pendFlag staying high while the stopwatch takes a fresh value. A second hard case is the exact commit latency. For that the raw tick is halted and then raised by hand at a known edge.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int ADDR_W      = 3;
  localparam int NUM_TARGETS = 5;

  typedef enum logic [ADDR_W-1:0] {
    SEL_TIME   = 3'd0,
    SEL_ALARM  = 3'd1,
    SEL_ICTL   = 3'd2,
    SEL_SWATCH = 3'd3,
    SEL_PREN   = 3'd4
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic commit;
  } strobe_t;

  function automatic logic addrHit(input logic [ADDR_W-1:0] a);
    return a < ADDR_W'(NUM_TARGETS);
  endfunction

endpackage

// File: rtl/tws_tick_sync.sv
module tws_tick_sync #(
  parameter int SYNC_STAGES  = 2,
  parameter int PRESCALE_DIV = 32768
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawTick,
  input  logic prenVal,
  output logic commitTick
);

  localparam int CNT_W = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;

  logic [SYNC_STAGES:0] syncChain;
  logic risePulse;
  logic secPulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) syncChain <= '0;
    else        syncChain <= {syncChain[SYNC_STAGES-1:0], rawTick};
  end

  assign risePulse = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  generate
    if (PRESCALE_DIV > 1) begin : g_div
      localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE_DIV - 1);
      logic [CNT_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          divCnt <= '0;
        else if (risePulse)  divCnt <= (divCnt == LAST) ? '0 : divCnt + 1'b1;
      end
      assign secPulse = risePulse && (divCnt == LAST);
    end else begin : g_nodiv
      assign secPulse = risePulse;
    end
  endgenerate

  assign commitTick = prenVal ? secPulse : risePulse;

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              commitTick,
  input  logic              doneClr,
  output strobe_t           strb,
  output logic              pendFlag,
  output logic              doneFlag
);

  logic accept;
  logic commit;

  assign commit = commitTick && pendFlag;
  assign accept = busWr && addrHit(busAddr) && (!pendFlag || commitTick);

  assign strb.capture = accept;
  assign strb.commit  = commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pendFlag <= 1'b0;
    else if (accept) pendFlag <= 1'b1;
    else if (commit) pendFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       doneFlag <= 1'b0;
    else if (commit)  doneFlag <= 1'b1;
    else if (doneClr) doneFlag <= 1'b0;
  end

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ICTL_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  output logic [DATA_W-1:0] timeVal,
  output logic [DATA_W-1:0] alarmVal,
  output logic [ICTL_W-1:0] intCtl,
  output logic [DATA_W-1:0] swVal,
  output logic              prenVal
);

  logic [ADDR_W-1:0]      capSel;
  logic [DATA_W-1:0]      capData;
  logic [NUM_TARGETS-1:0] hitVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capSel  <= '0;
      capData <= '0;
    end else if (strb.capture) begin
      capSel  <= busAddr;
      capData <= busData;
    end
  end

  for (genvar g = 0; g < NUM_TARGETS; g++) begin : g_hit
    assign hitVec[g] = strb.commit && (capSel == ADDR_W'(g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 timeVal <= '0;
    else if (hitVec[SEL_TIME])  timeVal <= capData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 alarmVal <= '0;
    else if (hitVec[SEL_ALARM]) alarmVal <= capData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                intCtl <= '0;
    else if (hitVec[SEL_ICTL]) intCtl <= capData[ICTL_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  swVal <= '0;
    else if (hitVec[SEL_SWATCH]) swVal <= capData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                prenVal <= 1'b1;
    else if (hitVec[SEL_PREN]) prenVal <= capData[0];
  end

endmodule

// File: rtl/tick_write_sync.sv
module tick_write_sync
  import tws_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int ICTL_W       = 16,
  parameter int PRESCALE_DIV = 32768,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic              rawTick,
  input  logic              doneClr,
  output logic [DATA_W-1:0] timeVal,
  output logic [DATA_W-1:0] alarmVal,
  output logic [ICTL_W-1:0] intCtl,
  output logic [DATA_W-1:0] swVal,
  output logic              prenVal,
  output logic              pendFlag,
  output logic              doneFlag
);

  strobe_t strb;
  logic    commitTick;

  tws_tick_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .PRESCALE_DIV(PRESCALE_DIV)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_n),
    .rawTick   (rawTick),
    .prenVal   (prenVal),
    .commitTick(commitTick)
  );

  tws_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .commitTick(commitTick),
    .doneClr   (doneClr),
    .strb      (strb),
    .pendFlag  (pendFlag),
    .doneFlag  (doneFlag)
  );

  tws_datapath #(
    .DATA_W(DATA_W),
    .ICTL_W(ICTL_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .busAddr (busAddr),
    .busData (busData),
    .timeVal (timeVal),
    .alarmVal(alarmVal),
    .intCtl  (intCtl),
    .swVal   (swVal),
    .prenVal (prenVal)
  );

endmodule

// File: rtl/tws_checker.sv
module tws_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busWr,
  input logic [2:0]        busAddr,
  input logic              doneClr,
  input logic              commitTick,
  input logic              pendFlag,
  input logic              doneFlag,
  input logic [DATA_W-1:0] timeVal,
  input logic [DATA_W-1:0] alarmVal,
  input logic [DATA_W-1:0] swVal,
  input logic              prenVal
);

  a_r2_pend_rises: assert property (@(posedge clk) disable iff (!rst_n)
    (busWr && busAddr < 3'd5 && !pendFlag) |=> pendFlag);

  a_r3_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !commitTick |=> ($stable(timeVal) && $stable(alarmVal) && $stable(swVal)));

  a_r3_pend_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pendFlag && commitTick && !busWr) |=> !pendFlag);

  a_r4_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (doneFlag && !doneClr) |=> doneFlag);

  a_r4_done_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
    (!doneFlag && !pendFlag) |=> !doneFlag);

  a_r5_pend_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (pendFlag && !commitTick) |=> pendFlag);

  a_r6_handover: assert property (@(posedge clk) disable iff (!rst_n)
    (pendFlag && commitTick && busWr && busAddr < 3'd5) |=> pendFlag);

  a_r9_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (!pendFlag && busWr && busAddr > 3'd4) |=> !pendFlag);

  a_r10_pren_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !commitTick |=> $stable(prenVal));

endmodule

bind tick_write_sync tws_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busWr     (busWr),
  .busAddr   (busAddr),
  .doneClr   (doneClr),
  .commitTick(commitTick),
  .pendFlag  (pendFlag),
  .doneFlag  (doneFlag),
  .timeVal   (timeVal),
  .alarmVal  (alarmVal),
  .swVal     (swVal),
  .prenVal   (prenVal)
);

// File: tb/tick_write_sync_test.sv
`timescale 1ns/1ps
module tick_write_sync_test;

  localparam int DW  = 32;
  localparam int IW  = 16;
  localparam int DIV = 4;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          busWr = 0;
  logic [2:0]    busAddr = 0;
  logic [DW-1:0] busData = 0;
  logic          rawTick = 0;
  logic          doneClr = 0;
  logic [DW-1:0] timeVal, alarmVal, swVal;
  logic [IW-1:0] intCtl;
  logic          prenVal, pendFlag, doneFlag;

  int errors = 0;
  int checks = 0;
  bit tickRun = 1;
  int tickHalf = 3;

  always #2.5 clk = ~clk;

  tick_write_sync #(.DATA_W(DW), .ICTL_W(IW), .PRESCALE_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .busWr(busWr), .busAddr(busAddr), .busData(busData),
    .rawTick(rawTick), .doneClr(doneClr), .timeVal(timeVal), .alarmVal(alarmVal),
    .intCtl(intCtl), .swVal(swVal), .prenVal(prenVal), .pendFlag(pendFlag),
    .doneFlag(doneFlag)
  );

  // ---------------- behavioural reference model ----------------
  int          mSync[3];
  int          mCnt;
  bit          mPend, mDone, mPren;
  int          mSel;
  logic [DW-1:0] mData;
  logic [DW-1:0] mReg[4];

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mSync[i]) mSync[i] = 0;
      mCnt = 0; mPend = 0; mDone = 0; mPren = 1; mSel = 0; mData = 0;
      foreach (mReg[i]) mReg[i] = 0;
    end else begin
      bit rise, tick, commit, take;
      rise   = (mSync[1] == 1) && (mSync[2] == 0);
      tick   = mPren ? (rise && mCnt == DIV - 1) : rise;
      commit = tick && mPend;
      take   = busWr && (busAddr <= 4) && (!mPend || tick);
      if (commit) begin
        if (mSel == 4) mPren = mData[0];
        else if (mSel == 2) mReg[2] = {{(DW-IW){1'b0}}, mData[IW-1:0]};
        else mReg[mSel] = mData;
        mDone = 1;
      end else if (doneClr) mDone = 0;
      if (take) begin
        mPend = 1; mSel = int'(busAddr); mData = busData;
      end else if (commit) mPend = 0;
      if (rise) mCnt = (mCnt == DIV - 1) ? 0 : mCnt + 1;
      mSync[2] = mSync[1]; mSync[1] = mSync[0]; mSync[0] = int'(rawTick);
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    chk("R2 pending vs model", DW'(pendFlag), DW'(mPend));
    chk("R4 done vs model", DW'(doneFlag), DW'(mDone));
    chk("R3 time vs model", timeVal, mReg[0]);
    chk("R3 alarm vs model", alarmVal, mReg[1]);
    chk("R9 ictl vs model", DW'(intCtl), mReg[2]);
    chk("R3 stopwatch vs model", swVal, mReg[3]);
    chk("R10 pren vs model", DW'(prenVal), DW'(mPren));
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compareAll();
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    busWr = 1; busAddr = a; busData = d;
    step();
    busWr = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 300 && pendFlag; i++) step();
  endtask

  // raw slow clock generator
  initial begin
    int c = 0;
    forever begin
      @(negedge clk);
      c++;
      if (tickRun && c >= tickHalf) begin
        rawTick = ~rawTick;
        c = 0;
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int changes;
    logic [DW-1:0] last;
    repeat (4) @(negedge clk);
    rst_n = 1;
    step();
    // R1 reset state
    chk("R1 pend", DW'(pendFlag), 0);
    chk("R1 done", DW'(doneFlag), 0);
    chk("R1 time", timeVal, 0);
    chk("R1 ictl", DW'(intCtl), 0);
    chk("R1 pren", DW'(prenVal), 1);

    // R2 / R5: first write pends, second one is dropped
    waitIdle();
    wr(3'd0, 32'h0000_1234);
    chk("R2 pending raised", DW'(pendFlag), 1);
    chk("R2 target unchanged", timeVal, 0);
    wr(3'd0, 32'h0000_BEEF);
    waitIdle();
    chk("R5 dropped write", timeVal, 32'h0000_1234);
    chk("R4 done set", DW'(doneFlag), 1);
    repeat (3) step();
    chk("R4 done sticky", DW'(doneFlag), 1);
    doneClr = 1; step(); doneClr = 0;
    step();
    chk("R4 done cleared", DW'(doneFlag), 0);

    // R9 unmapped address ignored, narrow field
    wr(3'd6, 32'hFFFF_FFFF);
    chk("R9 unmapped no pend", DW'(pendFlag), 0);
    wr(3'd2, 32'hABCD_5678);
    waitIdle();
    chk("R9 ictl low field", DW'(intCtl), 32'h0000_5678);

    // R6: hold a write every cycle across the commit
    wr(3'd1, 32'h0000_0011);
    busWr = 1; busAddr = 3'd3;
    for (int i = 0; i < 200 && alarmVal != 32'h11; i++) begin
      busData = 32'h2200 + i;
      step();
    end
    busWr = 0;
    chk("R6 handover pending", DW'(pendFlag), 1);
    chk("R6 alarm committed", alarmVal, 32'h11);
    waitIdle();
    chk("R6 stopwatch from handover", DW'(swVal != 0), 1);

    // R7 prescaled rate: continuous writes, count commits
    changes = 0; last = swVal;
    busWr = 1; busAddr = 3'd3;
    for (int i = 0; i < 240; i++) begin
      busData = 32'h5000 + i;
      step();
      if (swVal != last) begin changes++; last = swVal; end
    end
    busWr = 0;
    chk("R7 commits with prescaler", DW'(changes >= 9 && changes <= 11), 1);

    // R10: prescaler enable goes through the synchronizer
    waitIdle();
    wr(3'd4, 32'h0);
    chk("R10 pren before commit", DW'(prenVal), 1);
    waitIdle();
    chk("R10 pren after commit", DW'(prenVal), 0);

    changes = 0; last = swVal;
    busWr = 1; busAddr = 3'd3;
    for (int i = 0; i < 240; i++) begin
      busData = 32'h6000 + i;
      step();
      if (swVal != last) begin changes++; last = swVal; end
    end
    busWr = 0;
    chk("R7 commits without prescaler", DW'(changes >= 39 && changes <= 41), 1);

    // R8 exact latency with hand-driven raw tick
    waitIdle();
    tickRun = 0;
    rawTick = 0;
    repeat (6) step();
    wr(3'd0, 32'h0000_0099);
    step();
    rawTick = 1;
    step();
    chk("R8 edge1 old", timeVal, 32'h0000_1234);
    step();
    chk("R8 edge2 old", timeVal, 32'h0000_1234);
    step();
    chk("R8 edge3 new", timeVal, 32'h0000_0099);
    chk("R8 pend cleared", DW'(pendFlag), 0);

    // mixed traffic against the model
    tickRun = 1; tickHalf = 2;
    for (int i = 0; i < 600; i++) begin
      busWr   = ($urandom_range(0, 3) == 0);
      busAddr = 3'($urandom_range(0, 7));
      busData = $urandom;
      doneClr = ($urandom_range(0, 5) == 0);
      step();
    end
    busWr = 0; doneClr = 0;
    repeat (20) step();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule